// File: doc/BRIEF.md
# Flash Write-Status Responder

This block is the status side of a flash memory's write path. An embedded algorithm sequencer tells it when a program or erase has been launched, when it has finished, and when an erase is suspended or resumed. A per-sector protection map is also an input. The block tracks the running operation and answers reads with a polling bit on data bit 7 and a ready/busy level. The array contents, command decoding and toggle bits are handled elsewhere. The array's own bit 7 for the read address comes in on `arr_dq7_i` and passes through whenever no status applies.

A start pulse stands for the rising edge of the final write-enable of a command sequence, so status begins in the cycle after it. A program aimed at a protected sector, or an erase whose selected sectors are all protected, does not touch the array. Instead the block holds a timed busy window and then returns to read mode. Both window lengths are set in clock cycles by parameters derived from the clock frequency. If only part of an erase selection is protected, the block hands the sequencer a mask with the protected sectors removed.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, `ry_by_o` is 1 (ready), `erase_mask_o` is 0 and `dq7_o` equals `arr_dq7_i` for any address.
- R2: While a program runs, a read at the program address returns the complement of the latched `prog_d7_i`. Reads at other addresses return `arr_dq7_i`. `ry_by_o` is 0.
- R3: One cycle after `prog_done_i` ends a program started from read mode, `ry_by_o` is 1 and `dq7_o` equals `arr_dq7_i`, which holds the true programmed bit.
- R4: While an erase runs, a read in a selected sector returns 0 and a read elsewhere returns `arr_dq7_i`. `ry_by_o` is 0. `erase_done_i` returns the block to read mode with `erase_mask_o` = 0.
- R5: The sector of an address is its top `SEC_BITS` bits. Bit i of `prot_map_i` protects sector i, and bit i of `erase_sel_i` selects sector i.
- R6: `susp_i` during an erase gives `ry_by_o` = 1, and reads in selected sectors return 1. `resume_i` restores erase status (busy, reads 0).
- R7: A program started during erase suspend reports the complement rule at its address and is busy. Its `prog_done_i` returns to suspend (ready, selected sectors read 1).
- R8: A program at a protected sector holds `ry_by_o` = 0 for exactly PROG_CYC cycles, with the complement bit at its address. It then returns to read mode, and `prog_done_i` is ignored during the window.
- R9: An erase whose selected sectors are all protected holds `ry_by_o` = 0 for exactly ERASE_CYC cycles, with selected sectors reading 0. It then returns to read mode, and `erase_mask_o` stays 0.
- R10: With a partly protected selection, `erase_mask_o` = `erase_sel_i` & ~`prot_map_i` latched at start, and the erase runs normally.
- R11: Start pulses while busy, `susp_i` outside a running erase and `erase_done_i` outside an erase are ignored. When both starts arrive together in read mode, the program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_start_i | input | 1 | Program launched (end of command sequence) |
| prog_addr_i | input | ADDR_W | Program address |
| prog_d7_i | input | 1 | Bit 7 of the datum being programmed |
| prog_done_i | input | 1 | Sequencer finished the program |
| erase_start_i | input | 1 | Erase launched |
| erase_sel_i | input | NSEC | Sectors selected for erase |
| erase_done_i | input | 1 | Sequencer finished the erase |
| susp_i | input | 1 | Enter erase suspend |
| resume_i | input | 1 | Leave erase suspend |
| prot_map_i | input | NSEC | Per-sector protection |
| rd_addr_i | input | ADDR_W | Read address |
| arr_dq7_i | input | 1 | Array bit 7 at the read address |
| dq7_o | output | 1 | Polling bit |
| ry_by_o | output | 1 | 1 = ready, 0 = busy |
| erase_mask_o | output | NSEC | Sectors the sequencer should actually erase |

## Verification
The bench counts the exact length of both protected-sector busy windows. A timer that is off by one, or that lets a stray `prog_done_i` end the window early, shows up as a wrong count. It reads the program address and neighbouring addresses during each phase. An inverted or missing complement, or status leaking onto unrelated addresses, would then miscompare. The suspend path is exercised with a program nested inside the suspend. A design that returned to read mode instead of suspend would show a selected sector reading the array rather than 1. Ignored-event cases watch `ry_by_o` and `erase_mask_o` right after the stray pulse, where an accepted command would show up as busy.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_PFAKE, ST_ERASE, ST_EFAKE, ST_ESUSP
  } fsr_state_e;
endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          en_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = en_i && (cnt_q == CW'(1));

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import flash_status_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEC_BITS  = 2,
  parameter int NSEC      = 4,
  parameter int PROG_CYC  = 50,
  parameter int ERASE_CYC = 5000,
  parameter int CW        = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic              prog_d7_i,
  input  logic              prog_done_i,
  input  logic              erase_start_i,
  input  logic [NSEC-1:0]   erase_sel_i,
  input  logic              erase_done_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic [NSEC-1:0]   prot_map_i,
  input  logic              tmr_done_i,
  output fsr_state_e        st_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pd7_o,
  output logic              in_susp_o,
  output logic [NSEC-1:0]   sel_o,
  output logic [NSEC-1:0]   mask_o,
  output logic              tmr_load_o,
  output logic [CW-1:0]     tmr_val_o,
  output logic              tmr_en_o
);
  fsr_state_e        st_q, st_n;
  logic [ADDR_W-1:0] paddr_q, paddr_n;
  logic              pd7_q, pd7_n, susp_q, susp_n;
  logic [NSEC-1:0]   sel_q, sel_n, mask_q, mask_n;
  logic [SEC_BITS-1:0] psec;
  logic              pprot;
  logic [NSEC-1:0]   emask;

  assign psec  = prog_addr_i[ADDR_W-1 -: SEC_BITS];
  assign pprot = prot_map_i[psec];
  assign emask = erase_sel_i & ~prot_map_i;

  always_comb begin
    st_n = st_q; paddr_n = paddr_q; pd7_n = pd7_q; susp_n = susp_q;
    sel_n = sel_q; mask_n = mask_q;
    tmr_load_o = 1'b0; tmr_val_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (prog_start_i) begin
          paddr_n = prog_addr_i; pd7_n = prog_d7_i; susp_n = 1'b0;
          st_n = pprot ? ST_PFAKE : ST_PROG;
          tmr_load_o = pprot; tmr_val_o = CW'(PROG_CYC);
        end else if (erase_start_i) begin
          sel_n  = erase_sel_i;
          mask_n = emask;
          st_n   = (emask == '0) ? ST_EFAKE : ST_ERASE;
          tmr_load_o = (emask == '0); tmr_val_o = CW'(ERASE_CYC);
        end
      end
      ST_PROG:  if (prog_done_i) st_n = susp_q ? ST_ESUSP : ST_IDLE;
      ST_PFAKE: if (tmr_done_i)  st_n = susp_q ? ST_ESUSP : ST_IDLE;
      ST_ERASE: begin
        if (erase_done_i) begin
          st_n = ST_IDLE; sel_n = '0; mask_n = '0;
        end else if (susp_i) st_n = ST_ESUSP;
      end
      ST_EFAKE: if (tmr_done_i) begin st_n = ST_IDLE; sel_n = '0; end
      ST_ESUSP: begin
        if (prog_start_i) begin
          paddr_n = prog_addr_i; pd7_n = prog_d7_i; susp_n = 1'b1;
          st_n = pprot ? ST_PFAKE : ST_PROG;
          tmr_load_o = pprot; tmr_val_o = CW'(PROG_CYC);
        end else if (resume_i) st_n = ST_ERASE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; paddr_q <= '0; pd7_q <= 1'b0; susp_q <= 1'b0;
      sel_q <= '0; mask_q <= '0;
    end else begin
      st_q <= st_n; paddr_q <= paddr_n; pd7_q <= pd7_n; susp_q <= susp_n;
      sel_q <= sel_n; mask_q <= mask_n;
    end
  end

  assign tmr_en_o  = (st_q == ST_PFAKE) || (st_q == ST_EFAKE);
  assign st_o      = st_q;
  assign paddr_o   = paddr_q;
  assign pd7_o     = pd7_q;
  assign in_susp_o = susp_q;
  assign sel_o     = sel_q;
  assign mask_o    = mask_q;

  assert_prog_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && prog_start_i) |=> (st_q == ST_PROG || st_q == ST_PFAKE));
  assert_done_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG && prog_done_i && !susp_q) |=> (st_q == ST_IDLE));
  assert_resume_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ESUSP && resume_i && !prog_start_i) |=> (st_q == ST_ERASE));
  assert_fake_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EFAKE && !tmr_done_i) |=> (st_q == ST_EFAKE));
  assert_susp_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && susp_i && !prog_start_i && !erase_start_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/fsr_dq7.sv
module fsr_dq7
  import flash_status_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SEC_BITS = 2,
  parameter int NSEC     = 4
) (
  input  fsr_state_e        st_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              pd7_i,
  input  logic              in_susp_i,
  input  logic [NSEC-1:0]   sel_i,
  input  logic              arr_dq7_i,
  output logic              dq7_o
);
  logic [SEC_BITS-1:0] rsec;
  logic                sel_hit, amatch;

  assign rsec    = rd_addr_i[ADDR_W-1 -: SEC_BITS];
  assign sel_hit = sel_i[rsec];
  assign amatch  = (rd_addr_i == paddr_i);

  always_comb begin
    unique case (st_i)
      ST_PROG, ST_PFAKE: dq7_o = amatch ? ~pd7_i : ((in_susp_i && sel_hit) ? 1'b1 : arr_dq7_i);
      ST_ERASE, ST_EFAKE: dq7_o = sel_hit ? 1'b0 : arr_dq7_i;
      ST_ESUSP: dq7_o = sel_hit ? 1'b1 : arr_dq7_i;
      default:  dq7_o = arr_dq7_i;
    endcase
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_status_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SEC_BITS     = 2,
  parameter int CLK_MHZ      = 50,
  parameter int PROG_WIN_US  = 1,
  parameter int ERASE_WIN_US = 100
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_start_i,
  input  logic [ADDR_W-1:0]     prog_addr_i,
  input  logic                  prog_d7_i,
  input  logic                  prog_done_i,
  input  logic                  erase_start_i,
  input  logic [2**SEC_BITS-1:0] erase_sel_i,
  input  logic                  erase_done_i,
  input  logic                  susp_i,
  input  logic                  resume_i,
  input  logic [2**SEC_BITS-1:0] prot_map_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic                  arr_dq7_i,
  output logic                  dq7_o,
  output logic                  ry_by_o,
  output logic [2**SEC_BITS-1:0] erase_mask_o
);
  localparam int NSEC      = 2**SEC_BITS;
  localparam int PROG_CYC  = CLK_MHZ * PROG_WIN_US;
  localparam int ERASE_CYC = CLK_MHZ * ERASE_WIN_US;
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  fsr_state_e        st;
  logic [ADDR_W-1:0] paddr;
  logic              pd7, in_susp, tmr_load, tmr_en, tmr_done;
  logic [NSEC-1:0]   sel;
  logic [CW-1:0]     tmr_val;

  fsr_ctrl #(
    .ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS), .NSEC(NSEC),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni, .prog_start_i, .prog_addr_i, .prog_d7_i, .prog_done_i,
    .erase_start_i, .erase_sel_i, .erase_done_i, .susp_i, .resume_i, .prot_map_i,
    .tmr_done_i(tmr_done), .st_o(st), .paddr_o(paddr), .pd7_o(pd7),
    .in_susp_o(in_susp), .sel_o(sel), .mask_o(erase_mask_o),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_en_o(tmr_en)
  );

  fsr_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val),
    .en_i(tmr_en), .done_o(tmr_done)
  );

  fsr_dq7 #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS), .NSEC(NSEC)) u_dq7 (
    .st_i(st), .rd_addr_i, .paddr_i(paddr), .pd7_i(pd7), .in_susp_i(in_susp),
    .sel_i(sel), .arr_dq7_i, .dq7_o
  );

  assign ry_by_o = (st == ST_IDLE) || (st == ST_ESUSP);

  assert_mask_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EFAKE) |-> (erase_mask_o == '0));
endmodule

// File: tb/sim_flash_status_resp.sv
module sim_flash_status_resp;
  localparam int PROG_CYC  = 50;
  localparam int ERASE_CYC = 5000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       prog_start = 0, prog_d7 = 0, prog_done = 0;
  logic [7:0] prog_addr = 0, rd_addr = 0;
  logic       erase_start = 0, erase_done = 0, susp = 0, resume = 0, arr_dq7 = 0;
  logic [3:0] erase_sel = 0, prot_map = 0, erase_mask;
  logic       dq7, ry_by;
  int         nvec = 0, nerr = 0;

  always #10ns clk = ~clk;

  flash_status_resp u0 (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .prog_addr_i(prog_addr),
    .prog_d7_i(prog_d7), .prog_done_i(prog_done), .erase_start_i(erase_start),
    .erase_sel_i(erase_sel), .erase_done_i(erase_done), .susp_i(susp), .resume_i(resume),
    .prot_map_i(prot_map), .rd_addr_i(rd_addr), .arr_dq7_i(arr_dq7),
    .dq7_o(dq7), .ry_by_o(ry_by), .erase_mask_o(erase_mask)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic arr, input string req, input int exp);
    rd_addr = a; arr_dq7 = arr; #1ns;
    chk(req, int'(dq7), exp);
  endtask

  // drive at negedge, release at next negedge; result visible on return
  task automatic pulse_prog(input logic [7:0] a, input logic d7);
    @(negedge clk); prog_start = 1; prog_addr = a; prog_d7 = d7;
    @(negedge clk); prog_start = 0;
  endtask
  task automatic pulse_erase(input logic [3:0] s);
    @(negedge clk); erase_start = 1; erase_sel = s;
    @(negedge clk); erase_start = 0;
  endtask
  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic t_reset;
    rd(8'h00, 1'b1, "R1 dq7 pass", 1);
    rd(8'hC3, 1'b0, "R1 dq7 pass", 0);
    chk("R1 ready", int'(ry_by), 1);
    chk("R1 mask", int'(erase_mask), 0);
  endtask

  task automatic t_prog;
    prot_map = 4'b0000;
    pulse_prog(8'h12, 1'b1);
    chk("R2 busy", int'(ry_by), 0);
    rd(8'h12, 1'b0, "R2 complement", 0);
    rd(8'h13, 1'b1, "R2 other addr", 1);
    repeat (5) @(negedge clk);
    chk("R2 still busy", int'(ry_by), 0);
    pulse(prog_done);
    chk("R3 ready", int'(ry_by), 1);
    rd(8'h12, 1'b1, "R3 true datum", 1);
    pulse_prog(8'h20, 1'b0);
    rd(8'h20, 1'b0, "R2 complement d0", 1);
    pulse(prog_done);
    rd(8'h20, 1'b0, "R3 true datum d0", 0);
  endtask

  task automatic t_prog_prot;
    int n = 0;
    prot_map = 4'b0100;
    pulse_prog(8'h85, 1'b0);
    rd_addr = 8'h85; arr_dq7 = 1'b0;
    while (!ry_by && n < PROG_CYC + 20) begin
      #1ns;
      if (dq7 != 1'b1) chk("R8 complement in window", int'(dq7), 1);
      n++;
      if (n == 10) prog_done = 1;
      @(negedge clk);
      prog_done = 0;
    end
    chk("R8 window length", n, PROG_CYC);
    rd(8'h85, 1'b0, "R8 back to read", 0);
    prot_map = 4'b0000;
  endtask

  task automatic t_erase;
    prot_map = 4'b0000;
    pulse_erase(4'b0011);
    chk("R4 busy", int'(ry_by), 0);
    chk("R4 mask", int'(erase_mask), 3);
    rd(8'h05, 1'b1, "R4 sel sector0", 0);
    rd(8'h45, 1'b1, "R5 sel sector1", 0);
    rd(8'hC5, 1'b1, "R5 unselected sector3", 1);
    pulse(erase_done);
    chk("R4 done ready", int'(ry_by), 1);
    chk("R4 done mask", int'(erase_mask), 0);
    rd(8'h05, 1'b1, "R4 read mode", 1);
  endtask

  task automatic t_partial;
    prot_map = 4'b0010;
    pulse_erase(4'b0011);
    chk("R10 mask", int'(erase_mask), 1);
    chk("R10 busy", int'(ry_by), 0);
    prot_map = 4'b0000; #1ns;
    chk("R10 mask latched", int'(erase_mask), 1);
    pulse(erase_done);
    chk("R10 ready", int'(ry_by), 1);
  endtask

  task automatic t_all_prot;
    int n = 0;
    prot_map = 4'b1100;
    pulse_erase(4'b1000);
    chk("R9 mask", int'(erase_mask), 0);
    rd_addr = 8'hC0; arr_dq7 = 1'b1;
    while (!ry_by && n < ERASE_CYC + 20) begin
      #1ns;
      if (dq7 != 1'b0) chk("R9 zero in window", int'(dq7), 0);
      n++;
      @(negedge clk);
    end
    chk("R9 window length", n, ERASE_CYC);
    rd(8'hC0, 1'b1, "R9 back to read", 1);
    prot_map = 4'b0000;
  endtask

  task automatic t_susp;
    pulse_erase(4'b0010);
    pulse(susp);
    chk("R6 ready in suspend", int'(ry_by), 1);
    rd(8'h40, 1'b0, "R6 sel reads 1", 1);
    rd(8'h00, 1'b0, "R6 other passes", 0);
    pulse_prog(8'h10, 1'b0);
    chk("R7 busy", int'(ry_by), 0);
    rd(8'h10, 1'b0, "R7 complement", 1);
    rd(8'h40, 1'b0, "R7 suspended sector", 1);
    pulse(prog_done);
    chk("R7 back to suspend", int'(ry_by), 1);
    rd(8'h40, 1'b0, "R7 sel reads 1", 1);
    pulse(resume);
    chk("R6 resume busy", int'(ry_by), 0);
    rd(8'h40, 1'b1, "R6 resume reads 0", 0);
    pulse(erase_done);
    chk("R6 done ready", int'(ry_by), 1);
  endtask

  task automatic t_ignored;
    pulse(susp);
    chk("R11 susp idle", int'(ry_by), 1);
    pulse(erase_done);
    chk("R11 done idle", int'(ry_by), 1);
    pulse_erase(4'b0001);
    pulse_prog(8'h44, 1'b1);
    rd(8'h44, 1'b1, "R11 prog ignored in erase", 1);
    pulse(erase_done);
    chk("R11 ready after erase", int'(ry_by), 1);
    pulse_prog(8'h30, 1'b1);
    pulse_erase(4'b1111);
    chk("R11 mask while prog", int'(erase_mask), 0);
    pulse(prog_done);
    chk("R11 ready after prog", int'(ry_by), 1);
    chk("R11 no erase", int'(erase_mask), 0);
    // simultaneous starts: program wins
    @(negedge clk); prog_start = 1; erase_start = 1; prog_addr = 8'h01; prog_d7 = 1; erase_sel = 4'b0001;
    @(negedge clk); prog_start = 0; erase_start = 0;
    chk("R11 prog priority mask", int'(erase_mask), 0);
    rd(8'h01, 1'b1, "R11 prog priority dq7", 0);
    pulse(prog_done);
  endtask

  initial begin
    #2_000_000ns;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog();
    t_prog_prot();
    t_erase();
    t_partial();
    t_all_prot();
    t_susp();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule